// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block is a register-programmed master for the two-wire PHY management bus using the 32-bit Clause 22 frame. Software composes a complete management frame in one 32-bit frame register. Writing that register starts a serial transaction at once. The block then runs MDC from the module clock and either drives MDIO or releases it to the PHY. On a read, the 16 bits returned by the PHY land in the low half of the same frame register. The rest of the register keeps what software wrote.

When a transaction ends, a sticky completion flag is set. Software clears the flag by writing 1 to it. The flag drives an interrupt line through a mask bit. A control register sets three things: the MDC half-period in module clock cycles, the delay from each MDC falling edge to the MDIO update, and whether the 32-bit all-ones preamble is sent or skipped.

Top module: `mdio_frame_ctrl`

## Requirements
- R1: Registers are selected by the 2-bit word index. 0 is the frame register. 1 is the event register, with the completion flag at bit 0 and the read-only busy status at bit 1. 2 is the mask register, with the enable at bit 0. 3 is the control register, with the divider in bits [5:0], the hold count in bits [10:8] and preamble skip at bit 12. All registers reset to 0, and read data is combinational from the index.
- R2: A write to the frame register starts a transaction. With preamble enabled, 32 one-bits are sent first. Frame bits 31 down to 0 follow, one bit per MDC period and MSB first. The frame fields are: start code at [31:30], opcode at [29:28], PHY address at [27:23], register address at [22:18], turnaround at [17:16] and data at [15:0].
- R3: With the skip bit set, the preamble is omitted. The transaction then takes exactly 32 MDC periods, beginning with frame bit 31.
- R4: When the opcode is 10 (read), the output enable is low for frame bits 17 down to 0. MDIO is sampled on the rising MDC edge of each of the 16 data bits.
- R5: After a read completes, frame register bits [15:0] hold the sampled bits, with the first-sampled bit at bit 15. Bits [31:16] keep their written value.
- R6: MDC has a period of 2*(divider+1) module clock cycles during a transaction and stays low while idle.
- R7: The MDIO output changes exactly hold+1 module clock cycles after an MDC falling edge.
- R8: The completion flag sets when a transaction ends. Writing 1 to event bit 0 clears it, and writing 0 leaves it set.
- R9: The interrupt output is high only while both the completion flag and the mask enable are 1.
- R10: Busy is high from the frame write until the completion flag sets, and low afterwards.
- R11: For an opcode other than 10, the output enable stays high for all 32 frame bits, and the data field is sent after the turnaround.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |
| irq_o | output | 1 | Completion interrupt |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The hardest situation to reach is a read in which the master has released the line and the returned data must be timed exactly to the MDC edges. This is harder still with the preamble skipped, where the bit count shifts by 32. The bench contains a responder that counts rising MDC edges from the frame write. It computes the frame bit index from that count and the skip setting, and on each falling edge it drives the next turnaround or data bit. Separate monitors time every MDIO change against the last falling MDC edge and every MDC period against the programmed divider. This lets divider and hold settings be checked across the whole transaction rather than at one point.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_W  = 32;
  localparam int PRE_LEN  = 32;
  localparam int SEQ_W    = FRAME_W + PRE_LEN;
  localparam int IDX_W    = $clog2(SEQ_W);
  localparam int DATA_W   = 16;
  localparam int OP_LSB   = 28;
  localparam int HOLD_LSB = 8;
  localparam int SKIP_BIT = 12;
  localparam logic [1:0] OP_READ = 2'b10;

  typedef enum logic [1:0] {
    A_FRAME = 2'd0,
    A_EVENT = 2'd1,
    A_MASK  = 2'd2,
    A_CTRL  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
  parameter int DIV_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             mdc_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             mdc_q;
  logic             term;

  assign term = (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i || clr_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (term) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // edge strobes are valid in the cycle before mdc_o toggles
  assign rise_o = run_i && !clr_i && term && !mdc_q;
  assign fall_o = run_i && !clr_i && term && mdc_q;
  assign mdc_o  = mdc_q;
endmodule

// File: rtl/mdio_hold_tmr.sv
module mdio_hold_tmr #(
  parameter int HOLD_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  logic              clr_i,
  input  logic [HOLD_W-1:0] hold_i,
  output logic              fire_o
);
  logic              pend_q;
  logic [HOLD_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else if (launch_i) begin
      pend_q <= 1'b1;
      cnt_q  <= hold_i;
    end else if (clr_i) begin
      pend_q <= 1'b0;
    end else if (pend_q) begin
      if (cnt_q == '0) pend_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign fire_o = pend_q && (cnt_q == '0);
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
  import mdio_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               skip_i,
  input  logic               rise_i,
  input  logic               fall_i,
  input  logic               fire_i,
  input  logic               mdio_i,
  output logic               run_o,
  output logic               done_o,
  output logic               launch_o,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               mdio_o,
  output logic               mdio_oe_o
);
  logic [SEQ_W-1:0]  sh_q;
  logic [IDX_W-1:0]  idx_q;
  logic              run_q, last_q, rd_q, out_q, oe_q;
  logic [DATA_W-1:0] cap_q;
  logic [4:0]        fbit;
  logic              in_frame, released;

  assign in_frame = idx_q[IDX_W-1];
  assign fbit     = idx_q[4:0];
  // turnaround and data phase of a read belong to the PHY
  assign released = rd_q && in_frame && (fbit >= 5'd14);

  assign done_o   = run_q && fall_i && last_q;
  assign launch_o = start_i || (run_q && fall_i && !last_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      idx_q  <= '0;
      run_q  <= 1'b0;
      last_q <= 1'b0;
      rd_q   <= 1'b0;
      cap_q  <= '0;
      out_q  <= 1'b0;
      oe_q   <= 1'b0;
    end else if (start_i) begin
      sh_q   <= skip_i ? {frame_i, {PRE_LEN{1'b1}}} : {{PRE_LEN{1'b1}}, frame_i};
      idx_q  <= skip_i ? IDX_W'(PRE_LEN) : '0;
      run_q  <= 1'b1;
      last_q <= 1'b0;
      rd_q   <= (frame_i[OP_LSB+:2] == OP_READ);
      cap_q  <= '0;
    end else if (run_q) begin
      if (done_o) begin
        run_q  <= 1'b0;
        last_q <= 1'b0;
        oe_q   <= 1'b0;
      end else if (rise_i) begin
        if (released && fbit[4]) cap_q <= {cap_q[DATA_W-2:0], mdio_i};
        sh_q <= {sh_q[SEQ_W-2:0], 1'b0};
        if (idx_q == IDX_W'(SEQ_W - 1)) last_q <= 1'b1;
        else                            idx_q  <= idx_q + 1'b1;
      end else if (fire_i) begin
        out_q <= released ? 1'b0 : sh_q[SEQ_W-1];
        oe_q  <= !released;
      end
    end
  end

  assign run_o     = run_q;
  assign rdata_o   = cap_q;
  assign mdio_o    = out_q;
  assign mdio_oe_o = oe_q;
endmodule

// File: rtl/mdio_frame_ctrl.sv
module mdio_frame_ctrl
  import mdio_pkg::*;
#(
  parameter int DIV_W  = 6,
  parameter int HOLD_W = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [1:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        irq_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  logic [FRAME_W-1:0] frame_q;
  logic               ev_q, mask_q, skip_q;
  logic [DIV_W-1:0]   div_q;
  logic [HOLD_W-1:0]  hold_q;
  logic               start, done, busy, launch, fire, rise, fall;
  logic [DATA_W-1:0]  cap;
  reg_addr_e          addr;

  assign addr  = reg_addr_e'(reg_addr_i);
  assign start = reg_we_i && (addr == A_FRAME);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= '0;
      ev_q    <= 1'b0;
      mask_q  <= 1'b0;
      skip_q  <= 1'b0;
      div_q   <= '0;
      hold_q  <= '0;
    end else begin
      if (start)
        frame_q <= reg_wdata_i;
      else if (done && frame_q[OP_LSB+:2] == OP_READ)
        frame_q[DATA_W-1:0] <= cap;

      if (done)
        ev_q <= 1'b1;
      else if (reg_we_i && addr == A_EVENT && reg_wdata_i[0])
        ev_q <= 1'b0;

      if (reg_we_i && addr == A_MASK) mask_q <= reg_wdata_i[0];

      if (reg_we_i && addr == A_CTRL) begin
        div_q  <= reg_wdata_i[DIV_W-1:0];
        hold_q <= reg_wdata_i[HOLD_LSB+:HOLD_W];
        skip_q <= reg_wdata_i[SKIP_BIT];
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (addr)
      A_FRAME: reg_rdata_o = frame_q;
      A_EVENT: reg_rdata_o[1:0] = {busy, ev_q};
      A_MASK:  reg_rdata_o[0] = mask_q;
      A_CTRL: begin
        reg_rdata_o[DIV_W-1:0]          = div_q;
        reg_rdata_o[HOLD_LSB+:HOLD_W]   = hold_q;
        reg_rdata_o[SKIP_BIT]           = skip_q;
      end
      default: reg_rdata_o = '0;
    endcase
  end

  assign irq_o = ev_q && mask_q;

  mdio_clk_gen #(.DIV_W(DIV_W)) i_clk_gen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy),
    .clr_i  (start),
    .div_i  (div_q),
    .mdc_o  (mdc_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  mdio_hold_tmr #(.HOLD_W(HOLD_W)) i_hold_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .launch_i (launch),
    .clr_i    (done),
    .hold_i   (hold_q),
    .fire_o   (fire)
  );

  mdio_shifter i_shifter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .frame_i   (reg_wdata_i),
    .skip_i    (skip_q),
    .rise_i    (rise),
    .fall_i    (fall),
    .fire_i    (fire),
    .mdio_i    (mdio_i),
    .run_o     (busy),
    .done_o    (done),
    .launch_o  (launch),
    .rdata_o   (cap),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o)
  );
endmodule

// File: rtl/mdio_frame_ctrl_chk.sv
module mdio_frame_ctrl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        we_i,
  input logic [1:0]  addr_i,
  input logic [31:0] wdata_i,
  input logic        irq_i,
  input logic        mdc_i,
  input logic        oe_i,
  input logic        ev_i,
  input logic        busy_i
);
  p_irq_needs_event_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_i) |-> ev_i);

  p_mdc_idle_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !mdc_i);

  p_oe_idle_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !oe_i);

  p_busy_end_flags_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> ev_i);

  p_write_zero_keeps_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i && we_i && addr_i == 2'd1 && !wdata_i[0]) |=> ev_i);
endmodule

bind mdio_frame_ctrl mdio_frame_ctrl_chk i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .we_i    (reg_we_i),
  .addr_i  (reg_addr_i),
  .wdata_i (reg_wdata_i),
  .irq_i   (irq_o),
  .mdc_i   (mdc_o),
  .oe_i    (mdio_oe_o),
  .ev_i    (ev_q),
  .busy_i  (busy)
);

// File: tb/test_mdio_frame_ctrl.sv
`timescale 1ns/1ps
module test_mdio_frame_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  mdio_frame_ctrl i_mdio_frame_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq), .mdc_o(mdc),
    .mdio_o(mdio_o), .mdio_oe_o(mdio_oe), .mdio_i(mdio_i)
  );

  // monitor and responder state
  int          nrise = 0;
  int          off = 32;
  logic        phy_rd = 1'b0;
  logic [15:0] phy_val = '0;
  logic        bit_q [64];
  logic        oe_q [64];
  realtime     t_fall = -1.0, t_rise = -1.0;
  realtime     hmin, hmax, pmin, pmax;

  always @(posedge mdc) begin
    if (nrise < 64) begin
      bit_q[nrise] = mdio_o;
      oe_q[nrise]  = mdio_oe;
    end
    if (t_rise >= 0) begin
      if ($realtime - t_rise < pmin) pmin = $realtime - t_rise;
      if ($realtime - t_rise > pmax) pmax = $realtime - t_rise;
    end
    t_rise = $realtime;
    nrise  = nrise + 1;
  end

  always @(negedge mdc) begin
    int k;
    t_fall = $realtime;
    k = nrise - off;
    if (phy_rd && k == 15)               mdio_i <= 1'b0;
    else if (phy_rd && k >= 16 && k <= 31) mdio_i <= phy_val[31-k];
    else                                 mdio_i <= 1'b1;
  end

  always @(mdio_o) begin
    if (t_fall >= 0) begin
      if ($realtime - t_fall < hmin) hmin = $realtime - t_fall;
      if ($realtime - t_fall > hmax) hmax = $realtime - t_fall;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic run_xfer(input logic [31:0] frame, input logic skip, input int div,
                          input int hold, input logic [15:0] val, input string tag);
    logic [31:0] r;
    int bad, n, k;
    logic is_rd;
    is_rd = (frame[29:28] == 2'b10);
    reg_write(2'd3, (32'(skip) << 12) | (32'(hold) << 8) | 32'(div));
    reg_write(2'd1, 32'h1);
    nrise = 0; off = skip ? 0 : 32; phy_rd = is_rd; phy_val = val;
    hmin = 1e9; hmax = -1.0; pmin = 1e9; pmax = -1.0;
    t_rise = -1.0;
    reg_write(2'd0, frame);
    t_fall = -1.0;
    reg_read(2'd1, r);
    chk({tag, " R10 busy during transfer"}, {30'd0, r[1:0]}, 32'h2);
    n = 0;
    do begin
      reg_read(2'd1, r);
      n++;
    end while (!r[0] && n < 20000);
    chk({tag, " R8 flag set at end"}, 32'(r[0]), 32'h1);
    chk({tag, " R10 busy cleared"}, 32'(r[1]), 32'h0);
    chk({tag, skip ? " R3 rise count" : " R2 rise count"}, 32'(nrise), skip ? 32 : 64);
    bad = 0;
    for (int i = 0; i < 64 && i < nrise; i++) begin
      k = i - off;
      if (k < 0) begin
        if (bit_q[i] !== 1'b1 || oe_q[i] !== 1'b1) bad++;
      end else if (is_rd && k >= 14) begin
        if (oe_q[i] !== 1'b0) bad++;
      end else begin
        if (bit_q[i] !== frame[31-k] || oe_q[i] !== 1'b1) bad++;
      end
    end
    chk({tag, is_rd ? " R4 released phase / R2 bits" : " R11 driven bits / R2 bits"}, 32'(bad), 0);
    chk({tag, " R6 mdc period ns"}, 32'(int'(pmax)), 32'(20 * 2 * (div + 1)));
    chk({tag, " R6 mdc period min ns"}, 32'(int'(pmin)), 32'(20 * 2 * (div + 1)));
    chk({tag, " R7 hold ns"}, 32'(int'(hmax)), 32'(20 * (hold + 1)));
    chk({tag, " R7 hold min ns"}, 32'(int'(hmin)), 32'(20 * (hold + 1)));
    reg_read(2'd0, r);
    chk({tag, is_rd ? " R5 read data in frame" : " R5 frame unchanged"}, r,
        is_rd ? {frame[31:16], val} : frame);
    chk({tag, " R6 mdc idle low"}, 32'(mdc), 0);
    phy_rd = 1'b0;
  endtask

  task automatic test_reset();
    logic [31:0] r;
    for (int a = 0; a < 4; a++) begin
      reg_read(2'(a), r);
      chk("R1 reset value", r, 32'h0);
    end
    chk("R9 irq low after reset", 32'(irq), 0);
    chk("R6 mdc low after reset", 32'(mdc), 0);
    chk("R4 oe low after reset", 32'(mdio_oe), 0);
  endtask

  task automatic test_ctrl_readback();
    logic [31:0] r;
    reg_write(2'd3, 32'h0000_152A);
    reg_read(2'd3, r);
    chk("R1 control readback", r, 32'h0000_152A);
    reg_write(2'd2, 32'h1);
    reg_read(2'd2, r);
    chk("R1 mask readback", r, 32'h1);
    reg_write(2'd2, 32'h0);
  endtask

  task automatic test_event_mask();
    logic [31:0] r;
    reg_write(2'd2, 32'h0);
    reg_read(2'd1, r);
    chk("R8 flag still set", 32'(r[0]), 1);
    chk("R9 irq masked", 32'(irq), 0);
    reg_write(2'd1, 32'h0);
    reg_read(2'd1, r);
    chk("R8 write 0 keeps flag", 32'(r[0]), 1);
    reg_write(2'd2, 32'h1);
    #1 chk("R9 irq when flag and mask", 32'(irq), 1);
    reg_write(2'd1, 32'h1);
    reg_read(2'd1, r);
    chk("R8 write 1 clears flag", 32'(r[0]), 0);
    chk("R9 irq drops with flag", 32'(irq), 0);
    reg_write(2'd2, 32'h0);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    test_ctrl_readback();
    run_xfer({2'b01, 2'b01, 5'h13, 5'h0A, 2'b10, 16'hA5C3}, 1'b0, 2, 1, 16'h0, "write");
    run_xfer({2'b01, 2'b10, 5'h05, 5'h11, 2'b10, 16'hFFFF}, 1'b0, 3, 0, 16'h5A3C, "read");
    run_xfer({2'b01, 2'b10, 5'h1F, 5'h02, 2'b10, 16'h0000}, 1'b1, 1, 0, 16'h8001, "read_skip");
    run_xfer({2'b01, 2'b01, 5'h01, 5'h1E, 2'b10, 16'h3C96}, 1'b1, 4, 2, 16'h0, "write_skip");
    test_event_mask();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule